// File: doc/BRIEF.md
# Fixed-Latency Memory Responder

This block sits on the memory side of a cache refill port. A requester presents a read or write. Each request carries a byte address, a byte count and up to `MAX_WORDS` words of write data. Writes go straight into a small internal word array. A read takes a snapshot of the addressed words in the same edge and parks it in a table of outstanding reads. Every table entry carries its own countdown. Once an entry's countdown has run out, it is handed back as a fill response, but only in a cycle where the requester raises `fill_accept`.

New requests are held off by a registered stall flag. A small gate state machine decides the flag at every edge. It moves to `ST_TICK_HOLD` when the periodic mode input is set and its phase counter is at zero. Otherwise it moves to `ST_FULL_HOLD` when the occupancy after that edge reaches the table depth. In all other cases it moves to `ST_OPEN`. The periodic transition takes priority over the full transition. The stall output is low only in `ST_OPEN`. A request is taken at a rising edge when `req_valid` is high and `req_stall` is low. When a fill leaves the table, the younger entries close the gap one place down, so the table always holds entries in arrival order.

Top module: `mem_resp_model`

## Requirements
- R1: A read taken at edge k makes its fill available in the cycle that follows edge k+LATENCY (LATENCY = 200 by default), provided `fill_accept` is high.
- R2: An entry whose countdown has reached zero stays in the table for as long as `fill_accept` stays low, and it is returned as soon as `fill_accept` rises.
- R3: When several entries have matured, the fill returns the one at the lowest table position, which is the oldest, one fill per cycle.
- R4: `fill_valid` is high only when `fill_accept` is high and a matured entry exists; otherwise `fill_valid`, `fill_addr` and `fill_data` are zero. The returned entry leaves the table at the next edge.
- R5: A request covers `req_size`/4 words, capped at MAX_WORDS. Word i sits at byte address base + 4*i, which is store index `req_addr[7:2]` + i, wrapping. Word i occupies `fill_data` bits [32*i +: 32]. Data words beyond the request length are zero.
- R6: Read data is the store content at the edge where the read is taken; later writes do not change it.
- R7: A taken write updates the store at that edge and produces no table entry and no fill.
- R8: With `stall_mode_en` high, `req_stall` is high in exactly one cycle of every 16, spaced 16 cycles apart. With it low and the table not full, `req_stall` stays low.
- R9: With 16 reads outstanding, `req_stall` is high. Requests presented while `req_stall` is high are ignored.
- R10: The stall flag is a register. The read that fills the table is taken, and the stall shows from the next cycle.
- R11: After an entry is returned, the remaining entries keep their relative order. A read taken later is placed behind them.
- R12: Reset empties the table, clears the phase counter and the store, and leaves `req_stall`, `fill_valid` and `fill_addr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_read | input | 1 | Request is a read |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Byte base address |
| req_size | input | SIZE_W | Request length in bytes |
| req_wdata | input | MAX_WORDS*WORD_W | Write words, word 0 in the low bits |
| fill_accept | input | 1 | Requester can take a fill this cycle |
| stall_mode_en | input | 1 | Enables the periodic stall |
| req_stall | output | 1 | New requests are refused this cycle |
| fill_valid | output | 1 | A fill is presented |
| fill_addr | output | ADDR_W | Base address of the returned read |
| fill_data | output | MAX_WORDS*WORD_W | Returned words, word 0 in the low bits |

## Verification
The bench measures the exact edge count from taking a read to its fill. An off-by-one in the countdown would move the fill a cycle early or late. It writes over an address while a read of it is still in flight. A design that reads the store at response time would then return the new words. It pops one entry and then adds a new one behind the remaining two. A broken compaction would return them out of order, return a stale copy, or return the newcomer early. It fills the table while holding a request, and it runs the periodic mode. These two scenarios catch a combinational or late stall, which would admit a seventeenth read or would stall at the wrong spacing.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

    // Bytes carried by one store word; the request length is size / this value.
    localparam int unsigned BYTES_PER_WORD = 4;

    // Request gate: why new requests are (or are not) being refused.
    typedef enum logic [1:0] {
        ST_OPEN      = 2'd0,
        ST_TICK_HOLD = 2'd1,
        ST_FULL_HOLD = 2'd2
    } gate_state_e;

endpackage

// File: rtl/mrm_store.sv
module mrm_store #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned MAX_WORDS = 4,
    parameter int unsigned MEM_WORDS = 64,
    parameter int unsigned LEN_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           base_addr,
    input  logic [LEN_W-1:0]            len,
    input  logic                        wr_en,
    input  logic [MAX_WORDS*WORD_W-1:0] wr_data,
    output logic [MAX_WORDS*WORD_W-1:0] rd_data
);

    localparam int unsigned MIDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

    logic [WORD_W-1:0] mem_q [MEM_WORDS];
    logic [MIDX_W-1:0] base_idx;
    logic [MIDX_W-1:0] word_idx [MAX_WORDS];

    // Word address = byte address / 4, wrapped to the array size.
    assign base_idx = base_addr[2 +: MIDX_W];

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        assign word_idx[w] = base_idx + MIDX_W'(w);
        assign rd_data[w*WORD_W +: WORD_W] =
            (LEN_W'(w) < len) ? mem_q[word_idx[w]] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < MEM_WORDS; m++) begin
                mem_q[m] <= '0;
            end
        end else if (wr_en) begin
            for (int w = 0; w < MAX_WORDS; w++) begin
                if (LEN_W'(w) < len) begin
                    mem_q[word_idx[w]] <= wr_data[w*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/mrm_pend_table.sv
module mrm_pend_table #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_BITS = 128,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned LATENCY   = 200
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    push,
    input  logic [ADDR_W-1:0]                       push_addr,
    input  logic [DATA_BITS-1:0]                    push_data,
    input  logic                                    fill_accept,
    output logic                                    pop,
    output logic [ADDR_W-1:0]                       pop_addr,
    output logic [DATA_BITS-1:0]                    pop_data,
    output logic [$clog2(DEPTH+1)-1:0]              occ,
    output logic [$clog2(DEPTH+1)-1:0]              occ_next
);

    localparam int unsigned CNT_W = $clog2(LATENCY + 1);
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [OCC_W-1:0]     occ_q;
    logic [CNT_W-1:0]     cnt_q  [DEPTH];
    logic [CNT_W-1:0]     cnt_d  [DEPTH];
    logic [ADDR_W-1:0]    addr_q [DEPTH];
    logic [ADDR_W-1:0]    addr_d [DEPTH];
    logic [DATA_BITS-1:0] data_q [DEPTH];
    logic [DATA_BITS-1:0] data_d [DEPTH];
    logic [DEPTH-1:0]     ready;
    logic [SEL_W-1:0]     sel;
    logic                 any_ready;
    logic [OCC_W-1:0]     push_pos;

    // Entries are kept packed in positions 0 .. occ_q-1, oldest at 0.
    for (genvar s = 0; s < DEPTH; s++) begin : g_ready
        assign ready[s] = (OCC_W'(s) < occ_q) && (cnt_q[s] == '0);
    end

    // Lowest matured position wins.
    always_comb begin
        sel = '0;
        for (int s = DEPTH - 1; s >= 0; s--) begin
            if (ready[s]) begin
                sel = SEL_W'(s);
            end
        end
    end

    assign any_ready = |ready;
    assign pop       = fill_accept & any_ready;
    assign pop_addr  = pop ? addr_q[sel] : '0;
    assign pop_data  = pop ? data_q[sel] : '0;
    assign push_pos  = occ_q - OCC_W'(pop);
    assign occ_next  = occ_q - OCC_W'(pop) + OCC_W'(push);
    assign occ       = occ_q;

    // Per slot: take the upper neighbour when the popped entry sits at or
    // below this slot, load a new read at the first free slot, and count down.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic                 shift_in;
        logic                 load;
        logic [CNT_W-1:0]     cnt_src;
        logic [ADDR_W-1:0]    addr_src;
        logic [DATA_BITS-1:0] data_src;

        assign shift_in = pop && (SEL_W'(s) >= sel);
        assign load     = push && (push_pos == OCC_W'(s));

        if (s < DEPTH - 1) begin : g_mid
            assign cnt_src  = shift_in ? cnt_q[s+1]  : cnt_q[s];
            assign addr_src = shift_in ? addr_q[s+1] : addr_q[s];
            assign data_src = shift_in ? data_q[s+1] : data_q[s];
        end else begin : g_last
            assign cnt_src  = cnt_q[s];
            assign addr_src = addr_q[s];
            assign data_src = data_q[s];
        end

        assign cnt_d[s]  = load ? CNT_W'(LATENCY)
                                : ((cnt_src != '0) ? cnt_src - 1'b1 : '0);
        assign addr_d[s] = load ? push_addr : addr_src;
        assign data_d[s] = load ? push_data : data_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                cnt_q[s]  <= '0;
                addr_q[s] <= '0;
                data_q[s] <= '0;
            end
        end else begin
            occ_q <= occ_next;
            for (int s = 0; s < DEPTH; s++) begin
                cnt_q[s]  <= cnt_d[s];
                addr_q[s] <= addr_d[s];
                data_q[s] <= data_d[s];
            end
        end
    end

endmodule

// File: rtl/mrm_throttle.sv
module mrm_throttle
    import mrm_pkg::*;
#(
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned STALL_PERIOD = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_en,
    input  logic [$clog2(DEPTH+1)-1:0] occ_next,
    output logic                       stall,
    output logic                       phase_zero
);

    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam int unsigned PH_W  = (STALL_PERIOD > 1) ? $clog2(STALL_PERIOD) : 1;

    gate_state_e       state_q;
    gate_state_e       state_d;
    logic [PH_W-1:0]   phase_q;

    assign phase_zero = (phase_q == '0);

    // Next gate state, decided from this cycle's phase and post-edge occupancy.
    always_comb begin
        if (mode_en && phase_zero) begin
            state_d = ST_TICK_HOLD;
        end else if (occ_next >= OCC_W'(DEPTH)) begin
            state_d = ST_FULL_HOLD;
        end else begin
            state_d = ST_OPEN;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs from the registered state.
    always_comb begin
        unique case (state_q)
            ST_OPEN:      stall = 1'b0;
            ST_TICK_HOLD: stall = 1'b1;
            ST_FULL_HOLD: stall = 1'b1;
            default:      stall = 1'b1;
        endcase
    end

    // Free-running phase counter, modulo STALL_PERIOD.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_W'(STALL_PERIOD - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/mem_resp_model.sv
module mem_resp_model
    import mrm_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned WORD_W       = 32,
    parameter int unsigned MAX_WORDS    = 4,
    parameter int unsigned SIZE_W       = 8,
    parameter int unsigned MEM_WORDS    = 64,
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned LATENCY      = 200,
    parameter int unsigned STALL_PERIOD = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_read,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [SIZE_W-1:0]           req_size,
    input  logic [MAX_WORDS*WORD_W-1:0] req_wdata,
    input  logic                        fill_accept,
    input  logic                        stall_mode_en,
    output logic                        req_stall,
    output logic                        fill_valid,
    output logic [ADDR_W-1:0]           fill_addr,
    output logic [MAX_WORDS*WORD_W-1:0] fill_data
);

    localparam int unsigned DATA_BITS = MAX_WORDS * WORD_W;
    localparam int unsigned LEN_W     = $clog2(MAX_WORDS + 1);
    localparam int unsigned OCC_W     = $clog2(DEPTH + 1);
    localparam int unsigned WSZ_W     = SIZE_W - $clog2(BYTES_PER_WORD);

    logic                 accept;
    logic                 push;
    logic                 wr_en;
    logic [WSZ_W-1:0]     words_raw;
    logic [LEN_W-1:0]     req_len;
    logic [DATA_BITS-1:0] rd_words;
    logic [OCC_W-1:0]     table_occ;
    logic [OCC_W-1:0]     occ_next;
    logic                 phase_zero;

    // Length in words = byte size / 4, capped at the data path width.
    assign words_raw = req_size[SIZE_W-1:$clog2(BYTES_PER_WORD)];
    assign req_len   = (words_raw > WSZ_W'(MAX_WORDS)) ? LEN_W'(MAX_WORDS)
                                                       : LEN_W'(words_raw);

    assign accept = req_valid & ~req_stall;
    assign push   = accept & req_read;
    assign wr_en  = accept & req_write;

    mrm_store #(
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS),
        .MEM_WORDS (MEM_WORDS),
        .LEN_W     (LEN_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_addr (req_addr),
        .len       (req_len),
        .wr_en     (wr_en),
        .wr_data   (req_wdata),
        .rd_data   (rd_words)
    );

    mrm_pend_table #(
        .ADDR_W    (ADDR_W),
        .DATA_BITS (DATA_BITS),
        .DEPTH     (DEPTH),
        .LATENCY   (LATENCY)
    ) table_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_addr   (req_addr),
        .push_data   (rd_words),
        .fill_accept (fill_accept),
        .pop         (fill_valid),
        .pop_addr    (fill_addr),
        .pop_data    (fill_data),
        .occ         (table_occ),
        .occ_next    (occ_next)
    );

    mrm_throttle #(
        .DEPTH        (DEPTH),
        .STALL_PERIOD (STALL_PERIOD)
    ) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (stall_mode_en),
        .occ_next   (occ_next),
        .stall      (req_stall),
        .phase_zero (phase_zero)
    );

endmodule

// File: rtl/mem_resp_model_chk.sv
module mem_resp_model_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned OCC_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_accept,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              req_stall,
    input logic              stall_mode_en,
    input logic [OCC_W-1:0]  table_occ,
    input logic              phase_zero
);

    // R4: a fill is only offered to a requester that can take it
    a_r4_fill_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> fill_accept);

    // R4: idle response carries a zero address
    a_r4_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |-> (fill_addr == '0));

    // R4: a fill implies something is outstanding
    a_r4_fill_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (table_occ != '0));

    // R9: a full table holds off new requests
    a_r9_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (table_occ >= OCC_W'(DEPTH)) |-> req_stall);

    // R9: occupancy never exceeds the table depth
    a_r9_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        table_occ <= OCC_W'(DEPTH));

    // R8: a periodic tick in stall mode stalls the following cycle
    a_r8_tick_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_mode_en && phase_zero) |=> req_stall);

    // R10: a stalled cycle adds no entry
    a_r10_stall_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall |=> (table_occ <= $past(table_occ)));

    // R11: at most one entry enters per cycle
    a_r11_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        !req_stall |=> (table_occ <= $past(table_occ) + 1'b1));

endmodule

bind mem_resp_model mem_resp_model_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .OCC_W  (OCC_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fill_accept   (fill_accept),
    .fill_valid    (fill_valid),
    .fill_addr     (fill_addr),
    .req_stall     (req_stall),
    .stall_mode_en (stall_mode_en),
    .table_occ     (table_occ),
    .phase_zero    (phase_zero)
);

// File: tb/mem_resp_model_tb_top.sv
module mem_resp_model_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 200;
    localparam int DEPTH      = 16;

    logic         clk;
    logic         rst_n;
    logic         req_valid;
    logic         req_read;
    logic         req_write;
    logic [31:0]  req_addr;
    logic [7:0]   req_size;
    logic [127:0] req_wdata;
    logic         fill_accept;
    logic         stall_mode_en;
    logic         req_stall;
    logic         fill_valid;
    logic [31:0]  fill_addr;
    logic [127:0] fill_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    mem_resp_model dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_read      (req_read),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .fill_accept   (fill_accept),
        .stall_mode_en (stall_mode_en),
        .req_stall     (req_stall),
        .fill_valid    (fill_valid),
        .fill_addr     (fill_addr),
        .fill_data     (fill_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request for one edge; starts and ends at a falling edge.
    task automatic issue(input bit rd, input bit wr, input logic [31:0] a,
                         input logic [7:0] sz, input logic [127:0] wd);
        req_valid = 1'b1; req_read = rd; req_write = wr;
        req_addr  = a;    req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_read = 1'b0; req_write = 1'b0;
    endtask

    // m counts edges since the read was taken.
    task automatic wait_fill(inout int m);
        while (!fill_valid && m < LAT + 100) begin
            @(negedge clk);
            m++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!req_stall, "R12 stall low after reset", 128'(req_stall), 0);
        check(!fill_valid && fill_addr == 0, "R12 no fill after reset",
              {fill_addr, 31'd0, fill_valid}, 0);
        fill_accept = 1'b1;
        @(negedge clk);
        check(!fill_valid, "R12 table empty after reset", 128'(fill_valid), 0);
    endtask

    task automatic t_write_then_read();
        int seen = 0;
        int m = 0;
        logic [127:0] exp = {32'hA0A0_0004, 32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001};
        fill_accept = 1'b1;
        issue(1'b0, 1'b1, 32'h40, 8'd16, exp);
        repeat (250) begin
            if (fill_valid) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R7 write gives no fill", 128'(seen), 0);
        issue(1'b1, 1'b0, 32'h40, 8'd16, '0);
        wait_fill(m);
        check(m == LAT, "R1 read latency", 128'(m), 128'(LAT));
        check(fill_addr == 32'h40, "R4 fill address", 128'(fill_addr), 128'h40);
        check(fill_data == exp, "R5 four words in order", fill_data, exp);
        @(negedge clk);
        check(!fill_valid, "R4 entry leaves after fill", 128'(fill_valid), 0);
    endtask

    task automatic t_partial();
        int m = 0;
        logic [127:0] exp = {64'd0, 32'hB0B0_0003, 32'hB0B0_0002};
        issue(1'b0, 1'b1, 32'h80, 8'd16,
              {32'hB0B0_0004, 32'hB0B0_0003, 32'hB0B0_0002, 32'hB0B0_0001});
        issue(1'b1, 1'b0, 32'h84, 8'd8, '0);
        wait_fill(m);
        check(fill_data == exp, "R5 two-word read, upper words zero", fill_data, exp);
        @(negedge clk);
    endtask

    task automatic t_capture();
        int m = 1;
        logic [127:0] old_w = {32'hA0A0_0004, 32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001};
        logic [127:0] new_w = {32'hC0C0_0004, 32'hC0C0_0003, 32'hC0C0_0002, 32'hC0C0_0001};
        issue(1'b1, 1'b0, 32'h40, 8'd16, '0);
        issue(1'b0, 1'b1, 32'h40, 8'd16, new_w);
        wait_fill(m);
        check(m == LAT, "R1 latency with write behind", 128'(m), 128'(LAT));
        check(fill_data == old_w, "R6 data captured at acceptance", fill_data, old_w);
        @(negedge clk);
        m = 0;
        issue(1'b1, 1'b0, 32'h40, 8'd16, '0);
        wait_fill(m);
        check(fill_data == new_w, "R7 store holds written words", fill_data, new_w);
        @(negedge clk);
    endtask

    task automatic t_hold();
        int bad = 0;
        fill_accept = 1'b0;
        issue(1'b1, 1'b0, 32'h80, 8'd4, '0);
        repeat (300) begin
            if (fill_valid || fill_addr != 0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R4 no fill while accept low", 128'(bad), 0);
        fill_accept = 1'b1;
        #1;
        check(fill_valid && fill_addr == 32'h80, "R2 matured entry waits for accept",
              {fill_addr, 31'd0, fill_valid}, {32'h80, 31'd0, 1'b1});
        check(fill_data == 128'hB0B0_0001, "R2 held entry data", fill_data, 128'hB0B0_0001);
        @(negedge clk);
        check(!fill_valid, "R4 held entry removed", 128'(fill_valid), 0);
    endtask

    task automatic t_order();
        int m = 0;
        fill_accept = 1'b0;
        issue(1'b1, 1'b0, 32'h40, 8'd4, '0);
        issue(1'b1, 1'b0, 32'h80, 8'd4, '0);
        issue(1'b1, 1'b0, 32'hC0, 8'd4, '0);
        repeat (205) @(negedge clk);
        fill_accept = 1'b1;
        #1;
        check(fill_valid && fill_addr == 32'h40, "R3 oldest matured first",
              128'(fill_addr), 128'h40);
        @(negedge clk);
        fill_accept = 1'b0;
        issue(1'b1, 1'b0, 32'h00, 8'd4, '0);
        fill_accept = 1'b1;
        #1;
        check(fill_valid && fill_addr == 32'h80, "R11 second entry after shift",
              128'(fill_addr), 128'h80);
        @(negedge clk); m = 1;
        check(fill_valid && fill_addr == 32'hC0, "R11 third entry after shift",
              128'(fill_addr), 128'hC0);
        @(negedge clk); m = 2;
        check(!fill_valid, "R11 newcomer not returned early", 128'(fill_valid), 0);
        wait_fill(m);
        check(m == LAT && fill_addr == 32'h00, "R11 newcomer behind, full latency",
              {64'(m), 64'(fill_addr)}, {64'(LAT), 64'h0});
        @(negedge clk);
    endtask

    task automatic t_full();
        int acc = 0;
        int first = -1;
        int fills = 0;
        fill_accept = 1'b0; stall_mode_en = 1'b0;
        req_valid = 1'b1; req_read = 1'b1; req_write = 1'b0;
        req_addr = 32'h40; req_size = 8'd4;
        for (int c = 0; c < 20; c++) begin
            if (!req_stall) acc++;
            else if (first < 0) first = c;
            @(negedge clk);
        end
        req_valid = 1'b0; req_read = 1'b0;
        check(acc == DEPTH, "R9 only 16 reads taken", 128'(acc), 128'(DEPTH));
        check(first == DEPTH, "R10 stall one cycle after 16th read",
              128'(first), 128'(DEPTH));
        check(req_stall, "R9 stall held while full", 128'(req_stall), 1);
        fill_accept = 1'b1;
        repeat (260) begin
            if (fill_valid) fills++;
            @(negedge clk);
        end
        check(fills == DEPTH, "R9 refused requests left no entry", 128'(fills), 128'(DEPTH));
        check(!req_stall, "R9 stall released after drain", 128'(req_stall), 0);
    endtask

    task automatic t_periodic();
        int highs = 0;
        int last = -1;
        int badgap = 0;
        stall_mode_en = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 64; c++) begin
            if (req_stall) begin
                highs++;
                if (last >= 0 && c - last != 16) badgap++;
                last = c;
            end
            @(negedge clk);
        end
        check(highs == 4, "R8 one stall per 16 cycles", 128'(highs), 4);
        check(badgap == 0, "R8 stall spacing 16", 128'(badgap), 0);
        stall_mode_en = 1'b0;
        repeat (2) @(negedge clk);
        highs = 0;
        repeat (40) begin
            if (req_stall) highs++;
            @(negedge clk);
        end
        check(highs == 0, "R8 no stall with mode off", 128'(highs), 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_write = 1'b0;
        req_addr = '0; req_size = '0; req_wdata = '0;
        fill_accept = 1'b0; stall_mode_en = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_then_read();
        t_partial();
        t_capture();
        t_hold();
        t_order();
        t_full();
        t_periodic();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule